// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address for a synchronous burst memory. A cycle starts when one of two active-low address strobes is sampled. The first is the processor strobe, which takes priority. The second is the controller strobe. The external address is then captured. Three chip enables are checked against the strobe that was accepted. If they match, a cycle starts. If they do not, the sequencer is deselected.

While a burst is active and no strobe acts, an active-low step request moves the two low address bits to the next beat. With the step request high, the address is held. A static order input selects the beat order. In interleaved order, the low bits are XORed with the beat count. In linear order, the beat count is added modulo four inside the aligned group of four. The upper address bits never change during a burst.

All outputs are registered. A clock enable freezes every register. A synchronous active-high reset clears the state.

Top module: `burst_addr_seq`

## Requirements
- R1: When a cycle starts, the `addr_in` value sampled on that edge appears on `addr_out`, with `start_pulse` high, one cycle after the edge.
- R2: The processor strobe (`cpu_strb_n` low) is accepted only when `sel_master_n` is low. When `sel_master_n` is high, it has no effect whatever `ctl_strb_n` is: the edge behaves as if neither strobe were low.
- R3: The controller strobe (`ctl_strb_n` low) is accepted only when `cpu_strb_n` is high on the same edge. `sel_master_n` does not block it: if `sel_master_n` is high, an accepted controller strobe gives a deselect.
- R4: The enables match when `sel_master_n` is low, `sel_hi` is high and `sel_lo_n` is low. An accepted strobe whose enables do not match raises `desel_pulse`, leaves `addr_out` unchanged and ends the burst, so that no continue or suspend follows.
- R5: On an edge where a strobe is accepted, `step_n` is ignored. The loaded address is not stepped.
- R6: During an active burst, an edge with no accepted strobe and `step_n` low raises `cont`. It advances the beat, and bits above bit 1 keep their value.
- R7: During an active burst, an edge with no accepted strobe and `step_n` high raises `susp`, and `addr_out` is held.
- R8: With `interleave` = 1, the low two bits follow base^1, base^2, base^3 over successive steps.
- R9: With `interleave` = 0, the low two bits follow (base+1), (base+2), (base+3), each taken modulo 4.
- R10: A step after the fourth beat wraps back to the loaded low bits, in either order.
- R11: While `clk_en` is low, no output changes.
- R12: After reset, `addr_out` is 0 and all four indications are low. With no burst active and no strobe accepted, all indications stay low and the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low freezes all registers |
| addr_in | input | 18 | External address |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| sel_master_n | input | 1 | Master chip enable, active low |
| sel_hi | input | 1 | Chip enable, active high |
| sel_lo_n | input | 1 | Chip enable, active low |
| interleave | input | 1 | Beat order: 1 = XOR, 0 = linear |
| addr_out | output | 18 | Current word address |
| start_pulse | output | 1 | A cycle started on the previous edge |
| desel_pulse | output | 1 | A deselect occurred on the previous edge |
| cont | output | 1 | The burst stepped on the previous edge |
| susp | output | 1 | The burst was held on the previous edge |

## Verification
Every result is due exactly one clock after the edge that sampled its stimulus, because each output comes straight from a register. A clock-enable-low cycle defers that result until the next enabled edge. The bench drives inputs just after a rising edge. It advances its behavioural model at the next edge and compares the whole output set 1 ns later. Each comparison therefore lines up with that single register stage. Directed sequences then pin the expected addresses as literal constants, for both beat orders, for the wrap and for the strobe priority cases.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_START = 3'd1,
    OP_DESEL = 3'd2,
    OP_CONT  = 3'd3,
    OP_SUSP  = 3'd4
  } bas_op_e;
endpackage

// File: rtl/bas_strobe_dec.sv
module bas_strobe_dec
  import bas_pkg::*;
(
  input  logic    cpu_strb_n,
  input  logic    ctl_strb_n,
  input  logic    step_n,
  input  logic    sel_master_n,
  input  logic    sel_hi,
  input  logic    sel_lo_n,
  input  logic    active,
  output bas_op_e op
);
  logic cpu_go;
  logic ctl_go;
  logic enables_ok;

  // processor strobe is gated by the master enable; controller strobe
  // yields to the processor strobe but is not gated by the master enable
  assign cpu_go     = !cpu_strb_n && !sel_master_n;
  assign ctl_go     = cpu_strb_n && !ctl_strb_n;
  assign enables_ok = !sel_master_n && sel_hi && !sel_lo_n;

  always_comb begin
    if (cpu_go || ctl_go) begin
      op = enables_ok ? OP_START : OP_DESEL;
    end else if (active) begin
      op = step_n ? OP_SUSP : OP_CONT;
    end else begin
      op = OP_IDLE;
    end
  end
endmodule

// File: rtl/bas_beat_gen.sv
module bas_beat_gen #(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_lo,
  input  logic [BURST_W-1:0] beat,
  input  logic               interleave,
  output logic [BURST_W-1:0] lo_out
);
  logic [BURST_W-1:0] xor_lo;
  logic [BURST_W-1:0] lin_lo;

  for (genvar i = 0; i < BURST_W; i++) begin : g_xor
    assign xor_lo[i] = base_lo[i] ^ beat[i];
  end

  // truncating add keeps the wrap inside the aligned group
  assign lin_lo = base_lo + beat;
  assign lo_out = interleave ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              sel_master_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_out,
  output logic              start_pulse,
  output logic              desel_pulse,
  output logic              cont,
  output logic              susp
);
  localparam int HI_W = ADDR_W - BURST_W;

  bas_op_e            op;
  logic               active_q;
  logic [BURST_W-1:0] base_lo_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nxt;
  logic [BURST_W-1:0] lo_nxt;
  logic [ADDR_W-1:0]  addr_q;
  logic               start_q, desel_q, cont_q, susp_q;

  bas_strobe_dec u_dec (
    .cpu_strb_n  (cpu_strb_n),
    .ctl_strb_n  (ctl_strb_n),
    .step_n      (step_n),
    .sel_master_n(sel_master_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .active      (active_q),
    .op          (op)
  );

  assign beat_nxt = beat_q + 1'b1;

  bas_beat_gen #(.BURST_W(BURST_W)) u_beat (
    .base_lo   (base_lo_q),
    .beat      (beat_nxt),
    .interleave(interleave),
    .lo_out    (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      base_lo_q <= '0;
      beat_q    <= '0;
      addr_q    <= '0;
      start_q   <= 1'b0;
      desel_q   <= 1'b0;
      cont_q    <= 1'b0;
      susp_q    <= 1'b0;
    end else if (clk_en) begin
      start_q <= (op == OP_START);
      desel_q <= (op == OP_DESEL);
      cont_q  <= (op == OP_CONT);
      susp_q  <= (op == OP_SUSP);
      case (op)
        OP_START: begin
          active_q  <= 1'b1;
          base_lo_q <= addr_in[BURST_W-1:0];
          beat_q    <= '0;
          addr_q    <= addr_in;
        end
        OP_DESEL: active_q <= 1'b0;
        OP_CONT: begin
          beat_q              <= beat_nxt;
          addr_q[BURST_W-1:0] <= lo_nxt;
        end
        default: ;
      endcase
    end
  end

  assign addr_out    = addr_q;
  assign start_pulse = start_q;
  assign desel_pulse = desel_q;
  assign cont        = cont_q;
  assign susp        = susp_q;

  // R1
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clk_en) && start_q) |-> (addr_q == $past(addr_in)));

  // R2
  cpu_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !cpu_strb_n && sel_master_n) |=> (!start_q && !desel_q));

  // R4
  desel_ends_chk: assert property (@(posedge clk) disable iff (rst)
    desel_q |=> (!cont_q && !susp_q));

  // R6
  hi_bits_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    cont_q |-> (addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])));

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    susp_q |-> $stable(addr_q));

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(addr_q) && $stable({start_q, desel_q, cont_q, susp_q})));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr_in[ADDR_W-1:BURST_W];
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b1;
  logic [17:0] addr_in = '0;
  logic        cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, step_n = 1'b1;
  logic        sel_master_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic        interleave = 1'b1;
  logic [17:0] addr_out;
  logic        start_pulse, desel_pulse, cont, susp;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_addr = 0, m_base = 0, m_beat = 0;
  bit m_act = 0, m_st = 0, m_ds = 0, m_ct = 0, m_sp = 0;
  string m_tag = "R12";

  always #5 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr_in(addr_in),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .sel_master_n(sel_master_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .interleave(interleave), .addr_out(addr_out), .start_pulse(start_pulse),
    .desel_pulse(desel_pulse), .cont(cont), .susp(susp)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit pg, cg, ok;
    int lo;
    if (rst) begin
      m_addr = 0; m_base = 0; m_beat = 0; m_act = 0;
      m_st = 0; m_ds = 0; m_ct = 0; m_sp = 0; m_tag = "R12";
      return;
    end
    if (!clk_en) begin m_tag = "R11"; return; end
    pg = !cpu_strb_n && !sel_master_n;
    cg = cpu_strb_n && !ctl_strb_n;
    ok = !sel_master_n && sel_hi && !sel_lo_n;
    m_st = 0; m_ds = 0; m_ct = 0; m_sp = 0;
    if (pg || cg) begin
      if (ok) begin
        m_st = 1; m_act = 1; m_base = addr_in; m_beat = 0; m_addr = addr_in; m_tag = "R1";
      end else begin
        m_ds = 1; m_act = 0; m_tag = "R4";
      end
    end else if (m_act) begin
      if (!step_n) begin
        m_ct = 1;
        m_beat = (m_beat + 1) % 4;
        lo = interleave ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
        m_addr = (m_base & 'h3FFFC) | lo;
        m_tag = interleave ? "R8" : "R9";
      end else begin
        m_sp = 1; m_tag = "R7";
      end
    end else m_tag = "R12";
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    check({m_tag, " addr"}, addr_out, m_addr);
    check({m_tag, " flags"}, {start_pulse, desel_pulse, cont, susp}, {m_st, m_ds, m_ct, m_sp});
  endtask

  task automatic drive(bit p, bit c, bit s, bit m, bit h, bit l, int a);
    cpu_strb_n = p; ctl_strb_n = c; step_n = s;
    sel_master_n = m; sel_hi = h; sel_lo_n = l; addr_in = a[17:0];
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    check("R12 reset addr", addr_out, 0);
    check("R12 reset flags", {start_pulse, desel_pulse, cont, susp}, 0);

    // R5: step low on the start edge is ignored; interleaved order R8, wrap R10
    interleave = 1'b1;
    drive(0, 1, 0, 0, 1, 0, 'h15551); cyc();
    check("R5 loaded unstepped", addr_out, 'h15551);
    drive(1, 1, 0, 0, 1, 0, 'h3FFFF); cyc();
    check("R8 beat1", addr_out, 'h15550);
    cyc(); check("R8 beat2", addr_out, 'h15553);
    drive(1, 1, 1, 0, 1, 0, 0); cyc();
    check("R7 hold", addr_out, 'h15553);
    drive(1, 1, 0, 0, 1, 0, 0); cyc();
    check("R8 beat3", addr_out, 'h15552);
    cyc(); check("R10 wrap xor", addr_out, 'h15551);
    check("R6 cont", cont, 1);

    // R9 linear order via controller strobe, wrap R10
    interleave = 1'b0;
    drive(1, 0, 1, 0, 1, 0, 'h15551); cyc();
    check("R3 ctl start", start_pulse, 1);
    drive(1, 1, 0, 0, 1, 0, 0); cyc();
    check("R9 beat1", addr_out, 'h15552);
    cyc(); check("R9 beat2", addr_out, 'h15553);
    cyc(); check("R9 beat3", addr_out, 'h15550);
    cyc(); check("R10 wrap lin", addr_out, 'h15551);

    // R2: processor strobe blocked by master enable, even with controller strobe low
    drive(0, 0, 1, 1, 1, 0, 'h00AAA); cyc();
    check("R2 blocked addr", addr_out, 'h15551);
    check("R2 blocked flags", {start_pulse, desel_pulse, cont, susp}, 4'b0001);
    // R3: controller strobe with master enable high gives deselect
    drive(1, 0, 0, 1, 1, 0, 'h00AAA); cyc();
    check("R3 desel", desel_pulse, 1);
    check("R4 addr kept", addr_out, 'h15551);
    drive(1, 1, 0, 0, 1, 0, 0); cyc();
    check("R4 no cont", {cont, susp}, 0);
    // R4: wrong secondary enables on processor strobe
    drive(0, 1, 0, 0, 0, 0, 'h01234); cyc();
    check("R4 desel sel_hi", desel_pulse, 1);
    drive(0, 1, 1, 0, 1, 1, 'h01234); cyc();
    check("R4 desel sel_lo", desel_pulse, 1);

    // R11: freeze
    drive(0, 1, 1, 0, 1, 0, 'h2ABCD); cyc();
    clk_en = 1'b0;
    drive(0, 1, 1, 0, 1, 0, 'h11111); cyc(); cyc();
    check("R11 frozen addr", addr_out, 'h2ABCD);
    check("R11 frozen flag", start_pulse, 1);
    clk_en = 1'b1;

    // mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      clk_en = ($urandom % 8) != 0;
      if ((i % 500) == 0) interleave = ~interleave;
      drive(($urandom % 5) != 0, ($urandom % 5) != 0, $urandom % 2,
            ($urandom % 6) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0, r);
      cyc();
    end

    rst = 1'b1; cyc(); rst = 1'b0;
    check("R12 re-reset", {addr_out, start_pulse, desel_pulse, cont, susp}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule